// File: doc/BRIEF.md
# External Bus Access-State Controller

This block runs CPU-side accesses to an external address space one state at a time. The space is divided into three areas, selected by the two most significant address bits. Each area has its own data width (8 or 16 bits), access length (2 or 3 states), wait mode and programmed wait count. A requester raises `reqValid` while the block is idle. The block then latches the request and the configuration of the decoded area, drives the address, and drives a read or write strobe through the T1, T2, Tw and T3 states. It inserts programmed and/or pin-controlled wait states where the configuration allows them, and pulses `done` once the data phase is over.

A 16-bit access to an area configured 8 bits wide is carried out as two byte cycles. The first byte cycle uses the even address and carries the upper byte; the second uses the odd address and carries the lower byte. A single `done` follows the second cycle. A burst-ROM flag overrides the main area's 2/3-state choice with a fixed build-time setting.

Top module: `ext_access_seq`

## Requirements
- R1: After reset, `busy`, `done`, `busRd` and `busWr` are all 0.
- R2: The area is picked from address bits [ADDR_W-1:ADDR_W-2]: 01 selects the large area (config index 1), 10 selects the auxiliary area (index 2), and 00 or 11 select the main area (index 0). Each area's access uses only that area's bits of `cfgWide`, `cfgThree`, its mode field and `cfgWaitCnt[2i+1:2i]`.
- R3: An area with `cfgThree[i]`=0 uses two states per byte cycle: T1 with the address valid and no strobe, then one strobed state. No wait state is ever added, whatever the mode, count or `extWait`.
- R4: A 3-state area with mode 00 uses T1, T2 and T3 (strobe high in T2 and T3), and `extWait` has no effect. The address stays stable while the strobe is high.
- R5: Mode 10 (programmed only) adds exactly `waitCnt` Tw states after T2, and `extWait` has no effect.
- R6: Mode 01 (pin only) samples `extWait` at the end of T2 and of each Tw, and adds a Tw state for every sample that is 1.
- R7: Mode 11 first adds `waitCnt` programmed Tw states. It then samples `extWait` at the end of the last of them (or of T2 when the count is 0), and keeps adding Tw states while the pin is 1.
- R8: The large area has a 1-bit mode `cfgModeLarge`: 0 behaves as mode 10 and 1 behaves as mode 11.
- R9: When `burstRom`=1, the main area's 2/3-state choice comes from parameter BURST_LEN3 (1 means 3-state) and `cfgThree[0]` is ignored. The other areas are unaffected.
- R10: A word access (`reqWord`=1) to an area with `cfgWide[i]`=0 runs two byte cycles on lane [7:0]. The first is at the even address with the upper byte; the second is at the odd address with the lower byte. A read returns {first, second} on `rdData`.
- R11: A word access to a 16-bit area runs one cycle at the even address on the full 16 bits. A byte access (`reqWord`=0) runs one cycle at the given address on lane [7:0], and its read returns {8'h00, byte}.
- R12: The area configuration and `burstRom` are latched when the request is accepted. Later changes do not affect the access in progress.
- R13: `done` is high for exactly one cycle, the cycle after the final state, with `busy` low and `rdData` valid. `reqValid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Access request, taken when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = 16-bit access, 0 = byte |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | 16 | Write data |
| cfgWide | input | 3 | Per-area 16-bit width select |
| cfgThree | input | 3 | Per-area 3-state select |
| cfgModeMain | input | 2 | Main area wait mode |
| cfgModeLarge | input | 1 | Large area wait mode |
| cfgModeAux | input | 2 | Auxiliary area wait mode |
| cfgWaitCnt | input | 6 | Per-area programmed wait count, 2 bits each |
| burstRom | input | 1 | Burst-ROM override for the main area |
| extWait | input | 1 | External wait request |
| busDin | input | 16 | External read data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Assembled read data |
| busAddr | output | ADDR_W | External address |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busWdata | output | 16 | External write data |

## Verification
The bench builds the block with ADDR_W=16 and BURST_LEN3=1. With that width, every area boundary can be reached with short literal addresses such as 0x4000, 0x8000 and 0xC000, and the model for external read data can be derived from the low address byte. BURST_LEN3=1 makes the override visible: a main area set to 2 states runs for 3 states plus its programmed waits. State and strobe cycles are counted from the ports, so each wait mode, including the pin-extended ones, is measured in exact cycles.

// File: rtl/ext_access_pkg.sv
package ext_access_pkg;
  localparam int NUM_AREAS = 3;
  localparam int WAIT_W    = 2;
  localparam int DATA_W    = 16;
  localparam int BYTE_W    = 8;

  typedef enum logic [2:0] {ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3} busStateT;
  typedef enum logic [1:0] {AREA_MAIN = 2'd0, AREA_LARGE = 2'd1, AREA_AUX = 2'd2} areaT;

  typedef struct packed {
    logic              threeState;
    logic              progWait;
    logic              pinWait;
    logic [WAIT_W-1:0] waitCnt;
    logic              split;
  } accCfgT;

  typedef struct packed {
    logic accept;
    logic strobe;
    logic sample;
    logic nextByte;
  } dpCtlT;
endpackage

// File: rtl/ext_access_dp.sv
module ext_access_dp
  import ext_access_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter bit BURST_LEN3 = 1'b1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCtlT                         ctl,
  input  logic                          reqWrite,
  input  logic                          reqWord,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  input  logic [NUM_AREAS-1:0]          cfgWide,
  input  logic [NUM_AREAS-1:0]          cfgThree,
  input  logic [1:0]                    cfgModeMain,
  input  logic                          cfgModeLarge,
  input  logic [1:0]                    cfgModeAux,
  input  logic [NUM_AREAS*WAIT_W-1:0]   cfgWaitCnt,
  input  logic                          burstRom,
  input  logic [DATA_W-1:0]             busDin,
  output accCfgT                        cfgQ,
  output logic [ADDR_W-1:0]             busAddr,
  output logic                          busRd,
  output logic                          busWr,
  output logic [DATA_W-1:0]             busWdata,
  output logic [DATA_W-1:0]             rdData
);
  localparam int TOP_LSB = ADDR_W - 2;

  // per-area normalised settings, one generate slot per area
  logic [NUM_AREAS-1:0] areaThree;
  logic [1:0]           areaMode [NUM_AREAS];
  logic [WAIT_W-1:0]    areaCnt  [NUM_AREAS];

  for (genvar g = 0; g < NUM_AREAS; g++) begin : gArea
    assign areaCnt[g] = cfgWaitCnt[g*WAIT_W +: WAIT_W];
    if (g == int'(AREA_MAIN)) begin : gMain
      assign areaThree[g] = burstRom ? BURST_LEN3 : cfgThree[g];
      assign areaMode[g]  = cfgModeMain;
    end else if (g == int'(AREA_LARGE)) begin : gLarge
      assign areaThree[g] = cfgThree[g];
      assign areaMode[g]  = {1'b1, cfgModeLarge};
    end else begin : gAux
      assign areaThree[g] = cfgThree[g];
      assign areaMode[g]  = cfgModeAux;
    end
  end

  areaT   area;
  accCfgT cfgD;

  always_comb begin
    unique case (reqAddr[ADDR_W-1:TOP_LSB])
      2'b01:   area = AREA_LARGE;
      2'b10:   area = AREA_AUX;
      default: area = AREA_MAIN;
    endcase
    cfgD.threeState = areaThree[area];
    cfgD.progWait   = areaThree[area] & areaMode[area][1];
    cfgD.pinWait    = areaThree[area] & areaMode[area][0];
    cfgD.waitCnt    = areaCnt[area];
    cfgD.split      = reqWord & ~cfgWide[area];
  end

  logic              writeQ;
  logic              wordQ;
  logic              hiPhase;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdQ;
  logic [ADDR_W-1:0] curAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      writeQ  <= 1'b0;
      wordQ   <= 1'b0;
      hiPhase <= 1'b0;
      wdataQ  <= '0;
      rdQ     <= '0;
      curAddr <= '0;
    end else begin
      if (ctl.accept) begin
        cfgQ    <= cfgD;
        writeQ  <= reqWrite;
        wordQ   <= reqWord;
        wdataQ  <= reqWdata;
        hiPhase <= cfgD.split;
        curAddr <= reqWord ? {reqAddr[ADDR_W-1:1], 1'b0} : reqAddr;
      end
      if (ctl.sample && !writeQ) begin
        if (cfgQ.split) begin
          if (hiPhase) rdQ[DATA_W-1:BYTE_W] <= busDin[BYTE_W-1:0];
          else         rdQ[BYTE_W-1:0]      <= busDin[BYTE_W-1:0];
        end else if (wordQ) begin
          rdQ <= busDin;
        end else begin
          rdQ <= {{(DATA_W-BYTE_W){1'b0}}, busDin[BYTE_W-1:0]};
        end
      end
      if (ctl.nextByte) begin
        curAddr[0] <= 1'b1;
        hiPhase    <= 1'b0;
      end
    end
  end

  always_comb begin
    if (cfgQ.split)
      busWdata = {{(DATA_W-BYTE_W){1'b0}},
                  hiPhase ? wdataQ[DATA_W-1:BYTE_W] : wdataQ[BYTE_W-1:0]};
    else if (wordQ)
      busWdata = wdataQ;
    else
      busWdata = {{(DATA_W-BYTE_W){1'b0}}, wdataQ[BYTE_W-1:0]};
  end

  assign busAddr = curAddr;
  assign busRd   = ctl.strobe & ~writeQ;
  assign busWr   = ctl.strobe & writeQ;
  assign rdData  = rdQ;
endmodule

// File: rtl/ext_access_ctrl.sv
module ext_access_ctrl
  import ext_access_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   extWait,
  input  accCfgT cfgQ,
  output dpCtlT  ctl,
  output logic   busy,
  output logic   done
);
  busStateT          state, nxt;
  logic [WAIT_W-1:0] waitLeft, nxtWait;
  logic              secondQ;
  logic              finishByte;
  logic              doneQ;

  always_comb begin
    nxt        = state;
    nxtWait    = waitLeft;
    finishByte = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) nxt = ST_T1;
      ST_T1: begin
        nxt     = ST_T2;
        nxtWait = cfgQ.waitCnt;
      end
      ST_T2, ST_TW: begin
        if (!cfgQ.threeState) begin
          finishByte = 1'b1;
        end else if (cfgQ.progWait && waitLeft != '0) begin
          nxt     = ST_TW;
          nxtWait = WAIT_W'(waitLeft - 1'b1);
        end else if (cfgQ.pinWait && extWait) begin
          nxt = ST_TW;
        end else begin
          nxt = ST_T3;
        end
      end
      ST_T3: finishByte = 1'b1;
      default: nxt = ST_IDLE;
    endcase
    if (finishByte) nxt = (cfgQ.split && !secondQ) ? ST_T1 : ST_IDLE;

    ctl.accept   = (state == ST_IDLE) && reqValid;
    ctl.strobe   = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
    ctl.sample   = finishByte;
    ctl.nextByte = finishByte && cfgQ.split && !secondQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitLeft <= '0;
      secondQ  <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      state    <= nxt;
      waitLeft <= nxtWait;
      doneQ    <= finishByte && !ctl.nextByte;
      if (ctl.accept)   secondQ <= 1'b0;
      if (ctl.nextByte) secondQ <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;
endmodule

// File: rtl/ext_access_seq.sv
module ext_access_seq
  import ext_access_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter bit BURST_LEN3 = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic                        reqWrite,
  input  logic                        reqWord,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [DATA_W-1:0]           reqWdata,
  input  logic [NUM_AREAS-1:0]        cfgWide,
  input  logic [NUM_AREAS-1:0]        cfgThree,
  input  logic [1:0]                  cfgModeMain,
  input  logic                        cfgModeLarge,
  input  logic [1:0]                  cfgModeAux,
  input  logic [NUM_AREAS*WAIT_W-1:0] cfgWaitCnt,
  input  logic                        burstRom,
  input  logic                        extWait,
  input  logic [DATA_W-1:0]           busDin,
  output logic                        busy,
  output logic                        done,
  output logic [DATA_W-1:0]           rdData,
  output logic [ADDR_W-1:0]           busAddr,
  output logic                        busRd,
  output logic                        busWr,
  output logic [DATA_W-1:0]           busWdata
);
  dpCtlT  ctl;
  accCfgT cfgQ;

  ext_access_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .extWait  (extWait),
    .cfgQ     (cfgQ),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done)
  );

  ext_access_dp #(.ADDR_W(ADDR_W), .BURST_LEN3(BURST_LEN3)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .reqWrite     (reqWrite),
    .reqWord      (reqWord),
    .reqAddr      (reqAddr),
    .reqWdata     (reqWdata),
    .cfgWide      (cfgWide),
    .cfgThree     (cfgThree),
    .cfgModeMain  (cfgModeMain),
    .cfgModeLarge (cfgModeLarge),
    .cfgModeAux   (cfgModeAux),
    .cfgWaitCnt   (cfgWaitCnt),
    .burstRom     (burstRom),
    .busDin       (busDin),
    .cfgQ         (cfgQ),
    .busAddr      (busAddr),
    .busRd        (busRd),
    .busWr        (busWr),
    .busWdata     (busWdata),
    .rdData       (rdData)
  );
endmodule

// File: rtl/ext_access_seq_chk.sv
module ext_access_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              busRd,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R13
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));  // R13
  AST_STROBE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |-> busy);  // R13
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busRd, busWr}));  // R4
  AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRd || busWr) |-> ($past(busy) && $stable(busAddr)));  // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ((busRd || busWr) && $past(busRd || busWr)) |-> ($stable(busAddr) && $stable(busRd)));  // R4
endmodule

bind ext_access_seq ext_access_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .busRd   (busRd),
  .busWr   (busWr),
  .busAddr (busAddr)
);

// File: tb/ext_access_seq_tb.sv
`timescale 1ns/1ps
module ext_access_seq_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [15:0]   reqWdata = '0;
  logic [2:0]    cfgWide = 3'b111, cfgThree = 3'b000;
  logic [1:0]    cfgModeMain = 2'b00, cfgModeAux = 2'b00;
  logic          cfgModeLarge = 1'b0;
  logic [5:0]    cfgWaitCnt = '0;
  logic          burstRom = 1'b0, extWait = 1'b0;
  logic [15:0]   busDin;
  logic          busy, done, busRd, busWr;
  logic [15:0]   rdData, busWdata;
  logic [AW-1:0] busAddr;

  int nChk = 0, nFail = 0;
  bit finished = 0;
  int gotStates, gotStrobes, gotBytes;
  logic [AW-1:0] capA0, capA1;
  logic [15:0]   capW0, capW1;

  always #2.5 clk = ~clk;

  // external memory model: upper lane is a scramble of the low address byte
  assign busDin = {busAddr[7:0] ^ 8'hA5, busAddr[7:0]};

  ext_access_seq #(.ADDR_W(AW), .BURST_LEN3(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqWord(reqWord),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .cfgWide(cfgWide), .cfgThree(cfgThree),
    .cfgModeMain(cfgModeMain), .cfgModeLarge(cfgModeLarge), .cfgModeAux(cfgModeAux),
    .cfgWaitCnt(cfgWaitCnt), .burstRom(burstRom), .extWait(extWait), .busDin(busDin),
    .busy(busy), .done(done), .rdData(rdData), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // runs one access; pinDrop: 0 = extWait never high, else pin drops at that strobe cycle
  task automatic runAccess(input logic [AW-1:0] addr, input bit wr, input bit word,
                           input logic [15:0] wd, input int pinDrop, input bit disturb);
    bit prevStb = 0;
    int guard = 0;
    @(negedge clk);
    reqAddr = addr; reqWrite = wr; reqWord = word; reqWdata = wd;
    extWait = (pinDrop != 0);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    gotStates = 0; gotStrobes = 0; gotBytes = 0;
    while (!done && guard < 300) begin
      bit stb;
      stb = busRd | busWr;
      if (busy) gotStates++;
      if (stb) begin
        gotStrobes++;
        if (!prevStb) begin
          gotBytes++;
          if (gotBytes == 1) begin capA0 = busAddr; capW0 = busWdata; end
          else               begin capA1 = busAddr; capW1 = busWdata; end
        end
        if (gotStrobes == pinDrop) extWait = 1'b0;
      end
      prevStb = stb;
      if (disturb && guard == 0) begin cfgThree = 3'b000; cfgWaitCnt = '0; burstRom = 1'b1; end
      if (disturb && guard == 2) begin reqValid = 1'b1; reqAddr = 16'h8000; end
      if (disturb && guard == 3) reqValid = 1'b0;
      guard++;
      @(negedge clk);
    end
    extWait = 1'b0;
  endtask

  task automatic expTiming(input string tag, input int st, input int sb, input int by);
    chk(gotStates == st, {tag, " states"}, gotStates, st);
    chk(gotStrobes == sb, {tag, " strobes"}, gotStrobes, sb);
    chk(gotBytes == by, {tag, " byte cycles"}, gotBytes, by);
  endtask

  task automatic expAfterDone(input string tag);
    @(negedge clk);
    chk(!done && !busy, {tag, " done single pulse, no restart"}, {done, busy}, 0);
  endtask

  task automatic testReset();
    chk(!busy && !done && !busRd && !busWr, "R1 reset idle", {busy, done, busRd, busWr}, 0);
  endtask

  task automatic testTwoState();
    cfgThree = 3'b000; cfgModeMain = 2'b11; cfgWaitCnt = 6'b111111;
    runAccess(16'h0123, 0, 0, 0, 99, 0);
    expTiming("R3 two-state", 2, 1, 1);
    chk(rdData == 16'h0023, "R11 byte read lane", rdData, 16'h0023);
    chk(capA0 == 16'h0123, "R11 byte address", capA0, 16'h0123);
    expAfterDone("R13");
  endtask

  task automatic testPlain();
    cfgThree = 3'b111; cfgModeMain = 2'b00; cfgWaitCnt = 6'b000011;
    runAccess(16'h0040, 0, 1, 0, 99, 0);
    expTiming("R4 three-state no wait", 3, 2, 1);
    chk(rdData == 16'hE540, "R11 word read wide", rdData, 16'hE540);
  endtask

  task automatic testProg();
    cfgThree = 3'b111; cfgModeAux = 2'b10; cfgWaitCnt = 6'b100000;
    runAccess(16'h8011, 0, 1, 0, 99, 0);
    expTiming("R5 programmed waits", 5, 4, 1);
    chk(capA0 == 16'h8010, "R11 word even address", capA0, 16'h8010);
    chk(rdData == 16'hB510, "R2 aux area read", rdData, 16'hB510);
  endtask

  task automatic testPin();
    cfgThree = 3'b111; cfgModeMain = 2'b01; cfgWaitCnt = 6'b000011;
    runAccess(16'h0200, 0, 0, 0, 3, 0);
    expTiming("R6 pin wait 2", 5, 4, 1);
    runAccess(16'h0200, 0, 0, 0, 1, 0);
    expTiming("R6 pin wait 0", 3, 2, 1);
  endtask

  task automatic testBoth();
    cfgThree = 3'b111; cfgModeAux = 2'b11; cfgWaitCnt = 6'b010000;
    runAccess(16'h8100, 0, 0, 0, 4, 0);
    expTiming("R7 programmed then pin", 6, 5, 1);
  endtask

  task automatic testLarge();
    cfgThree = 3'b010; cfgModeLarge = 1'b0; cfgWaitCnt = 6'b001000;
    runAccess(16'h4000, 0, 0, 0, 99, 0);
    expTiming("R8 large mode0", 5, 4, 1);
    cfgModeLarge = 1'b1;
    runAccess(16'h4000, 0, 0, 0, 4, 0);
    expTiming("R8 large mode1", 6, 5, 1);
    runAccess(16'hC000, 0, 0, 0, 0, 0);
    expTiming("R2 top 11 uses main", 2, 1, 1);
  endtask

  task automatic testBurst();
    burstRom = 1'b1; cfgThree = 3'b000; cfgModeMain = 2'b10; cfgWaitCnt = 6'b000001;
    runAccess(16'h0010, 0, 0, 0, 0, 0);
    expTiming("R9 burst forces main", 4, 3, 1);
    runAccess(16'h4010, 0, 0, 0, 0, 0);
    expTiming("R9 burst leaves large", 2, 1, 1);
    burstRom = 1'b0;
  endtask

  task automatic testSplit();
    cfgWide = 3'b011; cfgThree = 3'b000;
    runAccess(16'h8035, 0, 1, 0, 0, 0);
    expTiming("R10 split read", 4, 2, 2);
    chk(rdData == 16'h3435, "R10 split read data", rdData, 16'h3435);
    chk(capA0 == 16'h8034 && capA1 == 16'h8035, "R10 split addresses", capA1, 16'h8035);
    expAfterDone("R10");
    cfgWide = 3'b110; cfgThree = 3'b001; cfgModeMain = 2'b10; cfgWaitCnt = 6'b000001;
    runAccess(16'h0200, 1, 1, 16'hBEEF, 0, 0);
    expTiming("R10 split write", 8, 6, 2);
    chk(capW0 == 16'h00BE, "R10 upper byte first", capW0, 16'h00BE);
    chk(capW1 == 16'h00EF, "R10 lower byte second", capW1, 16'h00EF);
    cfgWide = 3'b111;
    runAccess(16'h0302, 1, 1, 16'h1234, 0, 0);
    chk(capW0 == 16'h1234 && gotBytes == 1, "R11 wide write", capW0, 16'h1234);
  endtask

  task automatic testLatch();
    cfgThree = 3'b001; cfgModeMain = 2'b10; cfgWaitCnt = 6'b000011; burstRom = 1'b0;
    runAccess(16'h0100, 0, 0, 0, 0, 1);
    expTiming("R12 config latched", 6, 5, 1);
    expAfterDone("R13 busy request ignored");
    burstRom = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testTwoState();
    testPlain();
    testProg();
    testPin();
    testBoth();
    testLarge();
    testBurst();
    testSplit();
    testLatch();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule